// File: doc/BRIEF.md
# Round-Robin Warp Issue Scheduler

This block chooses which resident warp goes next into a narrow SIMD pipeline. A warp of 32 threads passes through an 8-lane pipe in four back-to-back cycles. Because of this, the scheduler makes one decision per four-cycle window. During that window it reports which group of eight threads is in flight. Each warp slot combines two things: a valid flag from outside the block, and a parked flag kept inside the block. The parked flag is set while the warp waits on a long-latency operation. A warp can be chosen only when it is valid and not parked.

The choice rotates. The search starts at a pointer that sits one slot past the last warp issued, and it wraps around the pool. When no warp can be chosen in a window, nothing is issued and the pointer does not move. All outputs come from registers. The candidate set is sampled on the clock edge that closes cycle 3 of a window, and the result appears in cycle 0 of the next window.

Top module: `rr_warp_issue`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `issue_o` is 0, `lane_grp_o` is 0 and `issue_id_o` is 0.
- R2: `lane_grp_o` advances by one on every clock, through 0, 1, 2, 3 and back to 0.
- R3: `issue_o` can be 1 only in a cycle where `lane_grp_o` is 0. `issue_id_o` stays constant during the three cycles that follow, where `lane_grp_o` is 1, 2 and 3.
- R4: A warp is a candidate when, at the edge that ends the cycle where `lane_grp_o` is 3, its `warp_valid_i` bit is 1 and it is not parked. Only a candidate can be issued.
- R5: The issued warp is the first candidate found by counting upward from the pointer, wrapping from the highest slot to slot 0. After an issue, the pointer becomes the issued ID plus one, and slot N-1 wraps to 0.
- R6: If a window has no candidate, `issue_o` stays 0 in its cycle 0. Both `issue_id_o` and the pointer keep their previous values.
- R7: When `ll_start_i[w]` is 1 at a clock edge, warp w is parked from the next cycle on. This holds whatever its valid bit is.
- R8: When `ll_done_i[w]` is 1 at an edge while warp w is parked, the warp is no longer parked from the next cycle on.
- R9: When `ll_start_i[w]` and `ll_done_i[w]` are both 1 at the same edge, warp w ends up parked.
- R10: A `ll_done_i[w]` pulse for a warp that is not parked has no effect. The warp remains a candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| warp_valid_i | input | NUM_WARPS | Warp slot holds a live warp |
| ll_start_i | input | NUM_WARPS | Warp begins a long-latency operation |
| ll_done_i | input | NUM_WARPS | Long-latency operation of the warp has completed |
| issue_o | output | 1 | Issue strobe, in cycle 0 of a window |
| issue_id_o | output | $clog2(NUM_WARPS) | ID of the warp issued, held through the window |
| lane_grp_o | output | $clog2(WARP_THREADS/SIMD_LANES) | Group of eight threads in the pipe this cycle |

## Verification
The bench uses an eight-slot pool. Each pattern below separates a different fault.

- All slots valid and nothing parked: this gives a plain rotation and exposes pointer-advance errors.
- Sparse random valid masks: these force the search to wrap past unready slots and catch a wrong start point for the search.
- A window with an empty pool: this shows whether the pointer or the ID drifts when nothing is issued.
- Random start and done pulses, along with pulses that coincide on one warp and done pulses aimed at unparked warps: these separate the parking rules from one another.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  localparam int DEF_WARPS   = 32;
  localparam int DEF_THREADS = 32;
  localparam int DEF_LANES   = 8;

  function automatic int wrap_next(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

endpackage

// File: rtl/issue_window_ctr.sv
module issue_window_ctr
  import warp_sched_pkg::*;
#(
  parameter int GROUPS = 4,
  localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [GW-1:0] grp_o,
  output logic          last_o
);

  logic [GW-1:0] grp_q;
  logic [GW-1:0] grp_d;

  always_comb begin
    grp_d = GW'(wrap_next(int'(grp_q), GROUPS));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) grp_q <= '0;
    else        grp_q <= grp_d;
  end

  assign grp_o  = grp_q;
  assign last_o = (grp_q == GW'(GROUPS - 1));

  AST_GRP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_q != GW'(GROUPS - 1)) |=> (grp_q == $past(grp_q) + GW'(1))); // R2
  AST_GRP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_q == GW'(GROUPS - 1)) |=> (grp_q == '0)); // R2

endmodule

// File: rtl/warp_park_table.sv
module warp_park_table #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] valid_i,
  input  logic [N-1:0] start_i,
  input  logic [N-1:0] done_i,
  output logic [N-1:0] cand_o
);

  logic [N-1:0] parked_q;
  logic [N-1:0] parked_d;

  genvar w;
  generate
    for (w = 0; w < N; w++) begin : g_slot
      always_comb begin
        if (start_i[w])     parked_d[w] = 1'b1;
        else if (done_i[w]) parked_d[w] = 1'b0;
        else                parked_d[w] = parked_q[w];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) parked_q <= '0;
    else        parked_q <= parked_d;
  end

  assign cand_o = valid_i & ~parked_q;

  AST_PARK_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((parked_q & $past(start_i)) == $past(start_i))); // R7
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((parked_q & $past(done_i & ~start_i)) == '0)); // R8

endmodule

// File: rtl/rr_warp_picker.sv
module rr_warp_picker
  import warp_sched_pkg::*;
#(
  parameter int N    = 32,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sample_i,
  input  logic [N-1:0]   cand_i,
  output logic           issue_o,
  output logic [IDW-1:0] id_o
);

  logic [IDW-1:0] ptr_q, ptr_d;
  logic [IDW-1:0] id_q, id_d;
  logic           issue_q, issue_d;
  logic           found;
  logic [IDW-1:0] pick;
  int             idx;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    idx   = 0;
    for (int k = 0; k < N; k++) begin
      idx = int'(ptr_q) + k;
      if (idx >= N) idx = idx - N;
      if (!found && cand_i[idx]) begin
        found = 1'b1;
        pick  = IDW'(idx);
      end
    end
  end

  always_comb begin
    issue_d = 1'b0;
    id_d    = id_q;
    ptr_d   = ptr_q;
    if (sample_i && found) begin
      issue_d = 1'b1;
      id_d    = pick;
      ptr_d   = IDW'(wrap_next(int'(pick), N));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q <= 1'b0;
      id_q    <= '0;
      ptr_q   <= '0;
    end else begin
      issue_q <= issue_d;
      id_q    <= id_d;
      ptr_q   <= ptr_d;
    end
  end

  assign issue_o = issue_q;
  assign id_o    = id_q;

  AST_IDLE_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && (cand_i == '0)) |=> ($stable(ptr_q) && !issue_q)); // R6

endmodule

// File: rtl/rr_warp_issue.sv
module rr_warp_issue
  import warp_sched_pkg::*;
#(
  parameter int NUM_WARPS    = DEF_WARPS,
  parameter int WARP_THREADS = DEF_THREADS,
  parameter int SIMD_LANES   = DEF_LANES,
  localparam int GROUPS      = WARP_THREADS / SIMD_LANES,
  localparam int GW          = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int IDW         = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] warp_valid_i,
  input  logic [NUM_WARPS-1:0] ll_start_i,
  input  logic [NUM_WARPS-1:0] ll_done_i,
  output logic                 issue_o,
  output logic [IDW-1:0]       issue_id_o,
  output logic [GW-1:0]        lane_grp_o
);

  logic                 win_last;
  logic [NUM_WARPS-1:0] cand;

  issue_window_ctr #(.GROUPS(GROUPS)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .grp_o  (lane_grp_o),
    .last_o (win_last)
  );

  warp_park_table #(.N(NUM_WARPS)) u_park (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (warp_valid_i),
    .start_i (ll_start_i),
    .done_i  (ll_done_i),
    .cand_o  (cand)
  );

  rr_warp_picker #(.N(NUM_WARPS)) u_pick (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample_i (win_last),
    .cand_i   (cand),
    .issue_o  (issue_o),
    .id_o     (issue_id_o)
  );

  AST_STROBE_IN_GRP0: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o |-> (lane_grp_o == '0)); // R3
  AST_ID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_grp_o != '0) |-> $stable(issue_id_o)); // R3

endmodule

// File: tb/tb_rr_warp_issue.sv
`timescale 1ns/1ps
module tb_rr_warp_issue;

  localparam int NW  = 8;
  localparam int IDW = 3;
  localparam int GW  = 2;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NW-1:0]  warp_valid_i, ll_start_i, ll_done_i;
  logic           issue_o;
  logic [IDW-1:0] issue_id_o;
  logic [GW-1:0]  lane_grp_o;

  int n_tests = 0;
  int n_fail  = 0;

  int            m_grp, m_id, m_ptr;
  logic          m_issue;
  logic [NW-1:0] m_parked;
  int            prev_id;

  always #2.5 clk = ~clk;

  rr_warp_issue #(.NUM_WARPS(NW)) dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .warp_valid_i (warp_valid_i),
    .ll_start_i   (ll_start_i),
    .ll_done_i    (ll_done_i),
    .issue_o      (issue_o),
    .issue_id_o   (issue_id_o),
    .lane_grp_o   (lane_grp_o)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int rr_pick(input logic [NW-1:0] rdy, input int ptr);
    for (int k = 0; k < NW; k++) begin
      int ix;
      ix = (ptr + k) % NW;
      if (rdy[ix]) return ix;
    end
    return -1;
  endfunction

  // model advance across one clock edge using currently driven inputs
  task automatic model_step();
    int p;
    if (m_grp == 3) begin
      p = rr_pick(warp_valid_i & ~m_parked, m_ptr);
      if (p >= 0) begin
        m_issue = 1'b1; m_id = p; m_ptr = (p + 1) % NW;
      end else begin
        m_issue = 1'b0;
      end
    end else begin
      m_issue = 1'b0;
    end
    m_grp = (m_grp + 1) % 4;
    for (int w = 0; w < NW; w++) begin
      if (ll_start_i[w])     m_parked[w] = 1'b1;
      else if (ll_done_i[w]) m_parked[w] = 1'b0;
    end
  endtask

  task automatic run_phase(input string tag, input int mode, input int cycles);
    for (int c = 0; c < cycles; c++) begin
      chk("R2", "lane_grp", int'(lane_grp_o), m_grp);
      chk(tag, "issue", int'(issue_o), int'(m_issue));
      chk(tag, "issue_id", int'(issue_id_o), m_id);
      if (lane_grp_o != 0) chk("R3", "id hold", int'(issue_id_o), prev_id);
      if (issue_o) chk("R3", "strobe grp", int'(lane_grp_o), 0);
      prev_id = int'(issue_id_o);
      ll_start_i = '0;
      ll_done_i  = '0;
      case (mode)
        0: warp_valid_i = '1;
        1: warp_valid_i = NW'($urandom) & NW'($urandom);
        2: warp_valid_i = '0;
        3: begin
          warp_valid_i = NW'($urandom) | NW'($urandom);
          ll_start_i   = NW'($urandom) & NW'($urandom) & NW'($urandom);
          ll_done_i    = NW'($urandom) & NW'($urandom);
        end
        4: begin
          int w;
          warp_valid_i = '1;
          w = $urandom_range(NW - 1);
          ll_start_i[w] = 1'b1;
          ll_done_i[w]  = 1'b1;
        end
        5: begin
          warp_valid_i = '1;
          ll_done_i    = NW'($urandom) & ~m_parked;
        end
        default: warp_valid_i = '1;
      endcase
      model_step();
      @(negedge clk);
    end
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    warp_valid_i = '0; ll_start_i = '0; ll_done_i = '0;
    m_grp = 0; m_id = 0; m_ptr = 0; m_issue = 1'b0; m_parked = '0; prev_id = 0;
    repeat (3) @(negedge clk);
    chk("R1", "issue in reset", int'(issue_o), 0);
    chk("R1", "grp in reset", int'(lane_grp_o), 0);
    chk("R1", "id in reset", int'(issue_id_o), 0);
    rst_n = 1'b1;
    run_phase("R5", 0, 64);
    run_phase("R4", 1, 400);
    run_phase("R6", 2, 16);
    run_phase("R5", 1, 400);
    run_phase("R7", 3, 800);
    run_phase("R9", 4, 200);
    run_phase("R8", 0, 40);
    // park every slot, then confirm R6 behaviour with valid high
    ll_start_i = '1; warp_valid_i = '1;
    model_step();
    @(negedge clk);
    ll_start_i = '0;
    run_phase("R6", 0, 12);
    // release all, then done pulses on unparked warps
    ll_done_i = '1;
    model_step();
    @(negedge clk);
    ll_done_i = '0;
    run_phase("R10", 5, 200);
    run_phase("R8", 3, 800);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule